// File: doc/BRIEF.md
# Multi-Mode Local Interrupt Timer

This block is a per-core timer that raises a tagged interrupt request. It runs in one of three mutually exclusive modes chosen by a two-bit field of its control register: a one-shot countdown, a periodic countdown that reloads itself, or an absolute deadline compared against a free-running 64-bit timestamp supplied on an input. The countdown and the deadline comparator share one interrupt output. Every change of mode disarms whatever was running.

Software reaches four registers through a simple register port: control (vector, mask, mode), initial count, current count and the 64-bit deadline. Writes take effect on the clock edge where `wr_en` is sampled. Read data is registered and appears the cycle after `rd_en`. The interrupt leaves as a one-cycle pulse together with the vector held in the control register when the expiry occurred.

Top module: `mm_irq_timer`

## Requirements
- R1: Register addresses are 0 = control, 1 = initial count, 2 = current count and 3 = deadline. With the default 8-bit vector, control holds the vector in bits 7:0, the mask in bit 8 and the mode in bits 10:9. The mode codes are 00 one-shot, 01 periodic, 10 deadline and 11 reserved. Control reads back exactly as written, and only one mode's expiry logic can fire at a time.
- R2: In one-shot mode, writing a count N>0 produces one interrupt pulse N cycles after the write edge. The count then rests at zero with no further pulses.
- R3: In periodic mode, writing N>0 gives the first pulse N cycles after the write. After each pulse the counter reloads from the initial count on the following cycle, so later pulses come every N+1 cycles.
- R4: A write to the initial count while a countdown is running reloads the counter and restarts the timing from that write.
- R5: Writing zero to the initial count stops the timer in both countdown modes. No pulse follows and the current count reads zero.
- R6: The current-count register ignores writes. The initial count reads back the last value it accepted.
- R7: When the mask bit is set, an expiry raises no pulse. A masked expiry still disarms one-shot and deadline operation and still reloads a periodic count. Each pulse carries the vector in force when it fires.
- R8: A control write that changes the mode disarms the timer. Any running count stops and reads zero, and any armed deadline is cleared to zero.
- R9: In deadline mode, initial-count writes are ignored and the current count reads zero.
- R10: In deadline mode, a non-zero deadline arms the timer. A pulse follows one cycle after the timestamp is greater than or equal to the deadline, compared as unsigned 64-bit values. The deadline register then clears to zero, so each write gives at most one pulse.
- R11: Writing zero to the deadline register disarms the deadline timer.
- R12: The deadline register resets to zero. Outside deadline mode it reads zero and ignores writes.
- R13: In the reserved mode the timer stays disarmed. The interrupt output never stays high for two cycles in a row.
- R14: Read data is registered and appears on the cycle after `rd_en`. After reset all registers read zero and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| timestamp | input | 64 | Free-running timestamp counter |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector delivered with the request |

## Verification
A countdown loaded with N produces its pulse N cycles after the write edge, and a periodic timer repeats every N+1 cycles. A deadline pulse comes one cycle after the timestamp reaches the target, or after the arming write if the target has already passed. Read data lags `rd_en` by one cycle. The bench drives inputs on falling edges and samples on falling edges too. It counts whole cycles from the falling edge just after a write or timestamp change, so each expected latency is compared as an exact cycle count. Silence checks watch the pulse output over a window longer than any armed period, then read the state back through the register port.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_DEADLINE = 2'b10,
    MODE_RSVD     = 2'b11
  } mmt_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_INIT = 2'd1;
  localparam logic [1:0] REG_CUR  = 2'd2;
  localparam logic [1:0] REG_DL   = 2'd3;
endpackage

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_mask,
  input  logic [1:0]       wr_mode,
  output mmt_mode_e        mode,
  output logic             mask,
  output logic [VEC_W-1:0] vector,
  output logic             mode_chg
);
  mmt_mode_e new_mode;

  assign new_mode = mmt_mode_e'(wr_mode);
  assign mode_chg = wr_ctrl && (new_mode != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_ONESHOT;
      mask   <= 1'b0;
      vector <= '0;
    end else if (wr_ctrl) begin
      mode   <= new_mode;
      mask   <= wr_mask;
      vector <= wr_vec;
    end
  end

  AST_CTRL_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (mode == mmt_mode_e'($past(wr_mode))) && (vector == $past(wr_vec))); // R1
endmodule

// File: rtl/mmt_countdown.sv
module mmt_countdown
  import mmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  mmt_mode_e        mode,
  input  logic             disarm,
  input  logic             wr_init,
  input  logic [CNT_W-1:0] wr_val,
  output logic             expire,
  output logic             armed_q,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic cnt_mode;
  logic load;

  assign cnt_mode = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
  assign load     = wr_init && cnt_mode && !disarm;
  assign expire   = armed_q && !disarm && !load && (cur_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      init_q  <= '0;
      cur_q   <= '0;
    end else if (disarm) begin
      armed_q <= 1'b0;
      cur_q   <= '0;
    end else if (load) begin
      init_q  <= wr_val;
      cur_q   <= wr_val;
      armed_q <= (wr_val != '0);
    end else if (armed_q) begin
      if (cur_q != '0) begin
        cur_q <= cur_q - ONE;
        if ((cur_q == ONE) && (mode == MODE_ONESHOT)) armed_q <= 1'b0;
      end else begin
        cur_q <= init_q;
      end
    end
  end

  AST_ONESHOT_RESTS: assert property (@(posedge clk) disable iff (rst)
    (expire && mode == MODE_ONESHOT) |=> (!armed_q && cur_q == '0)); // R2
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (armed_q && cur_q == '0 && !wr_init && !disarm) |=> (cur_q == $past(init_q))); // R3
  AST_RESTART_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_q == $past(wr_val))); // R4
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
    (load && wr_val == '0) |=> !armed_q); // R5
  AST_MODE_CHANGE_STOPS: assert property (@(posedge clk) disable iff (rst)
    disarm |=> (!armed_q && cur_q == '0)); // R8
  AST_INIT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_init && !cnt_mode) |=> $stable(init_q)); // R9
endmodule

// File: rtl/mmt_deadline.sv
module mmt_deadline
  import mmt_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  mmt_mode_e       mode,
  input  logic            disarm,
  input  logic            wr_dl,
  input  logic [TS_W-1:0] wr_val,
  input  logic [TS_W-1:0] timestamp,
  output logic            expire,
  output logic [TS_W-1:0] dl_q
);
  logic in_dl;
  logic wr_acc;

  assign in_dl  = (mode == MODE_DEADLINE);
  assign wr_acc = wr_dl && in_dl && !disarm;
  assign expire = in_dl && !disarm && !wr_acc && (dl_q != '0) && (timestamp >= dl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_q <= '0;
    end else if (disarm) begin
      dl_q <= '0;
    end else if (wr_acc) begin
      dl_q <= wr_val;
    end else if (expire) begin
      dl_q <= '0;
    end
  end

  AST_DL_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    expire |=> (dl_q == '0)); // R10
  AST_DL_ZERO_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && wr_val == '0) |=> !expire); // R11
  AST_DL_IGNORED_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (wr_dl && !in_dl) |=> (dl_q == '0)); // R12
  AST_DL_CLEARED_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
    disarm |=> (dl_q == '0)); // R8
endmodule

// File: rtl/mm_irq_timer.sv
module mm_irq_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TS_W   = 64,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TS_W-1:0]   wr_data,
  output logic [TS_W-1:0]   rd_data,
  input  logic [TS_W-1:0]   timestamp,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int MASK_POS = VEC_W;
  localparam int MODE_POS = VEC_W + 1;

  mmt_mode_e        mode;
  logic             mask;
  logic [VEC_W-1:0] vector;
  logic             mode_chg;
  logic             wr_ctrl, wr_init, wr_dl;
  logic             cd_expire, dl_expire, fire;
  logic             cd_armed;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [TS_W-1:0]  dl_q;
  logic [TS_W-1:0]  rd_next;

  assign wr_ctrl = wr_en && (addr == REG_CTRL);
  assign wr_init = wr_en && (addr == REG_INIT);
  assign wr_dl   = wr_en && (addr == REG_DL);

  mmt_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_vec   (wr_data[VEC_W-1:0]),
    .wr_mask  (wr_data[MASK_POS]),
    .wr_mode  (wr_data[MODE_POS +: 2]),
    .mode     (mode),
    .mask     (mask),
    .vector   (vector),
    .mode_chg (mode_chg)
  );

  mmt_countdown #(.CNT_W(CNT_W)) u_countdown (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .disarm  (mode_chg),
    .wr_init (wr_init),
    .wr_val  (wr_data[CNT_W-1:0]),
    .expire  (cd_expire),
    .armed_q (cd_armed),
    .init_q  (init_q),
    .cur_q   (cur_q)
  );

  mmt_deadline #(.TS_W(TS_W)) u_deadline (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .disarm    (mode_chg),
    .wr_dl     (wr_dl),
    .wr_val    (wr_data),
    .timestamp (timestamp),
    .expire    (dl_expire),
    .dl_q      (dl_q)
  );

  assign fire = cd_expire || dl_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= fire && !mask;
      if (fire) irq_vector <= vector;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      REG_CTRL: begin
        rd_next[VEC_W-1:0]     = vector;
        rd_next[MASK_POS]      = mask;
        rd_next[MODE_POS +: 2] = mode;
      end
      REG_INIT: rd_next[CNT_W-1:0] = init_q;
      REG_CUR:  if (mode != MODE_DEADLINE) rd_next[CNT_W-1:0] = cur_q;
      default:  rd_next = dl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(cd_expire && dl_expire)); // R1
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(mask)); // R7
  AST_VECTOR_TAGGED: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_vector == $past(vector))); // R7
  AST_SINGLE_CYCLE_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse); // R13
  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RSVD) |-> (!cd_armed && dl_q == '0)); // R13
  AST_CUR_HIDDEN_IN_DL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_CUR && mode == MODE_DEADLINE) |=> (rd_data == '0)); // R9
endmodule

// File: tb/mm_irq_timer_tb.sv
module mm_irq_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [63:0] ts = '0;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mm_irq_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .timestamp(ts),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  function automatic logic [63:0] ctrl_word(input logic [1:0] m, input logic msk, input logic [7:0] v);
    return {53'd0, m, msk, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_pulse(input int maxc, output int k, output logic [7:0] v);
    k = -1; v = '0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (irq_pulse) begin k = i; v = irq_vector; break; end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  v;
    int k, n;
    void'($urandom(32'd20240));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(irq_pulse == 1'b0, "R14 reset irq", 64'(irq_pulse), 0);
    rd(2'd0, d); chk(d == 0, "R14 reset ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R14 reset init", d, 0);
    rd(2'd2, d); chk(d == 0, "R14 reset cur", d, 0);
    rd(2'd3, d); chk(d == 0, "R12 reset deadline", d, 0);

    // R1 control layout
    wr(2'd0, ctrl_word(2'b00, 1'b0, 8'h41));
    rd(2'd0, d); chk(d == ctrl_word(2'b00, 1'b0, 8'h41), "R1 ctrl readback", d, ctrl_word(2'b00, 1'b0, 8'h41));

    // R2 one-shot
    wr(2'd1, 64'd10);
    wait_pulse(40, k, v);
    chk(k == 10, "R2 one-shot latency", 64'(k), 10);
    chk(v == 8'h41, "R7 vector", 64'(v), 64'h41);
    wait_pulse(30, k, v);
    chk(k == -1, "R2 single pulse", 64'(k), 64'hffffffffffffffff);
    rd(2'd2, d); chk(d == 0, "R2 cur rests at zero", d, 0);
    rd(2'd1, d); chk(d == 10, "R6 init readback", d, 10);

    for (int it = 0; it < 12; it++) begin
      logic [7:0] rv;
      n = 1 + int'($urandom % 60);
      rv = 8'($urandom);
      wr(2'd0, ctrl_word(2'b00, 1'b0, rv));
      wr(2'd1, 64'(n));
      wait_pulse(80, k, v);
      chk(k == n, "R2 random one-shot latency", 64'(k), 64'(n));
      chk(v == rv, "R7 random vector", 64'(v), 64'(rv));
    end

    // R6 current count ignores writes
    wr(2'd2, 64'h55);
    rd(2'd2, d); chk(d == 0, "R6 cur write ignored", d, 0);

    // R4 restart
    wr(2'd0, ctrl_word(2'b00, 1'b0, 8'h41));
    wr(2'd1, 64'd40);
    repeat (15) @(negedge clk);
    wr(2'd1, 64'd8);
    wait_pulse(60, k, v);
    chk(k == 8, "R4 restart latency", 64'(k), 8);

    // R5 zero stops
    wr(2'd1, 64'd30);
    repeat (5) @(negedge clk);
    wr(2'd1, 64'd0);
    wait_pulse(60, k, v);
    chk(k == -1, "R5 zero stops one-shot", 64'(k), 64'hffffffffffffffff);
    rd(2'd2, d); chk(d == 0, "R5 cur zero", d, 0);

    // R3 periodic
    wr(2'd0, ctrl_word(2'b01, 1'b0, 8'h22));
    wr(2'd1, 64'd6);
    wait_pulse(20, k, v); chk(k == 6, "R3 first periodic", 64'(k), 6);
    wait_pulse(20, k, v); chk(k == 7, "R3 period", 64'(k), 7);
    wait_pulse(20, k, v); chk(k == 7, "R3 period again", 64'(k), 7);
    n = 6;
    for (int it = 0; it < 4; it++) begin
      n = 1 + int'($urandom % 30);
      wr(2'd1, 64'(n));
      wait_pulse(80, k, v); chk(k == n, "R3 random first", 64'(k), 64'(n));
      wait_pulse(80, k, v); chk(k == n + 1, "R3 random period", 64'(k), 64'(n + 1));
    end
    wr(2'd1, 64'd0);
    wait_pulse(50, k, v);
    chk(k == -1, "R5 zero stops periodic", 64'(k), 64'hffffffffffffffff);

    // R7 masked periodic keeps reloading
    wr(2'd1, 64'd9);
    wr(2'd0, ctrl_word(2'b01, 1'b1, 8'h22));
    wait_pulse(35, k, v);
    chk(k == -1, "R7 masked periodic silent", 64'(k), 64'hffffffffffffffff);
    wr(2'd0, ctrl_word(2'b01, 1'b0, 8'h22));
    wait_pulse(12, k, v);
    chk(k >= 1 && k <= 10, "R7 periodic resumes", 64'(k), 10);
    wait_pulse(20, k, v); chk(k == 10, "R7 period kept", 64'(k), 10);

    // R7 masked one-shot disarms; R8 mode change
    wr(2'd0, ctrl_word(2'b00, 1'b1, 8'h33));
    wr(2'd1, 64'd5);
    wait_pulse(20, k, v);
    chk(k == -1, "R7 masked one-shot silent", 64'(k), 64'hffffffffffffffff);
    wr(2'd0, ctrl_word(2'b00, 1'b0, 8'h33));
    wait_pulse(20, k, v);
    chk(k == -1, "R7 masked one-shot disarmed", 64'(k), 64'hffffffffffffffff);
    wr(2'd1, 64'd50);
    repeat (10) @(negedge clk);
    wr(2'd0, ctrl_word(2'b01, 1'b0, 8'h33));
    wait_pulse(120, k, v);
    chk(k == -1, "R8 mode change disarms", 64'(k), 64'hffffffffffffffff);
    rd(2'd2, d); chk(d == 0, "R8 cur cleared", d, 0);

    // R9 deadline mode gates countdown
    wr(2'd0, ctrl_word(2'b10, 1'b0, 8'h77));
    wr(2'd1, 64'd5);
    wait_pulse(20, k, v);
    chk(k == -1, "R9 init ignored", 64'(k), 64'hffffffffffffffff);
    rd(2'd1, d); chk(d == 50, "R9 init unchanged", d, 50);
    rd(2'd2, d); chk(d == 0, "R9 cur reads zero", d, 0);

    // R10 deadline
    ts = 64'd1000;
    wr(2'd3, 64'd1500);
    wait_pulse(10, k, v);
    chk(k == -1, "R10 early", 64'(k), 64'hffffffffffffffff);
    rd(2'd3, d); chk(d == 1500, "R10 deadline readback", d, 1500);
    ts = 64'd1499;
    wait_pulse(5, k, v);
    chk(k == -1, "R10 one below", 64'(k), 64'hffffffffffffffff);
    ts = 64'd1500;
    wait_pulse(5, k, v);
    chk(k == 1, "R10 fire on equal", 64'(k), 1);
    chk(v == 8'h77, "R7 deadline vector", 64'(v), 64'h77);
    rd(2'd3, d); chk(d == 0, "R10 self clear", d, 0);
    ts = 64'd5000;
    wait_pulse(10, k, v);
    chk(k == -1, "R10 at most once", 64'(k), 64'hffffffffffffffff);

    wr(2'd3, 64'h8000_0000_0000_0000);
    ts = 64'h7FFF_FFFF_FFFF_FFFF;
    wait_pulse(5, k, v);
    chk(k == -1, "R10 unsigned below", 64'(k), 64'hffffffffffffffff);
    ts = 64'hFFFF_FFFF_FFFF_FFF0;
    wait_pulse(5, k, v);
    chk(k == 1, "R10 unsigned above", 64'(k), 1);

    ts = 64'd2000;
    wr(2'd3, 64'd1999);
    wait_pulse(5, k, v);
    chk(k == 1, "R10 past deadline", 64'(k), 1);

    // R11 zero disarms
    ts = 64'd0;
    wr(2'd3, 64'd300);
    wr(2'd3, 64'd0);
    ts = 64'd400;
    wait_pulse(10, k, v);
    chk(k == -1, "R11 zero disarms", 64'(k), 64'hffffffffffffffff);

    // R7 masked deadline still clears
    wr(2'd0, ctrl_word(2'b10, 1'b1, 8'h77));
    ts = 64'd10;
    wr(2'd3, 64'd20);
    ts = 64'd30;
    wait_pulse(5, k, v);
    chk(k == -1, "R7 masked deadline silent", 64'(k), 64'hffffffffffffffff);
    rd(2'd3, d); chk(d == 0, "R7 masked deadline cleared", d, 0);

    // R8 leaving deadline mode clears it
    wr(2'd0, ctrl_word(2'b10, 1'b0, 8'h77));
    ts = 64'd0;
    wr(2'd3, 64'd900);
    wr(2'd0, ctrl_word(2'b00, 1'b0, 8'h77));
    rd(2'd3, d); chk(d == 0, "R8 deadline cleared", d, 0);
    ts = 64'd1000;
    wait_pulse(10, k, v);
    chk(k == -1, "R8 no deadline pulse", 64'(k), 64'hffffffffffffffff);

    // R12 outside deadline mode
    wr(2'd3, 64'd99);
    rd(2'd3, d); chk(d == 0, "R12 write ignored", d, 0);

    // R13 reserved mode
    wr(2'd0, ctrl_word(2'b11, 1'b0, 8'h11));
    wr(2'd1, 64'd7);
    wait_pulse(30, k, v);
    chk(k == -1, "R13 reserved idle", 64'(k), 64'hffffffffffffffff);
    rd(2'd2, d); chk(d == 0, "R13 reserved cur", d, 0);
    rd(2'd0, d); chk(d == ctrl_word(2'b11, 1'b0, 8'h11), "R1 reserved readback", d, ctrl_word(2'b11, 1'b0, 8'h11));

    finish_run();
  end
endmodule